// File: doc/BRIEF.md
# Byte-Stream Hamming Parity Generator

This block computes a Hamming-style error-correcting code over one 512-byte sector of data as the sector moves across a NAND flash data bus, in either direction. Bytes are presented with a valid strobe. A clear input starts a new sector. In word mode, each 16-bit transfer carries two bytes, and both are absorbed in a single cycle, low byte first. The block keeps two parity halves per code bit. For every bit position inside a byte and for every bit of the byte address, one half collects the data bits whose position has that index bit set. The other half collects the data bits whose position has it clear.

When the 512th byte has been absorbed, the 24-bit code is final. A single-cycle done pulse marks this point, and a small counter of completed sectors advances. The code then holds until the next clear. Software reads the code and XORs it with the code stored for the sector. A single flipped data bit gives a syndrome whose lower half is the flipped bit's address and whose upper half is the complement of that address.

Top module: `nand_hamming_ecc`

## Requirements
- R1: While reset is high, the code output is all zeros, done is low and the sector counter is zero.
- R2: Column parity bit k (k = 0, 1, 2) odd half is the XOR, over all bytes, of the data bits whose bit index has bit k set (k=0: bits 7,5,3,1). The even half is the XOR of the data bits whose bit index has bit k clear.
- R3: Row parity bit k (k = 0..8) odd half is the XOR of the whole-byte parity of every byte whose 9-bit address has bit k set. The even half uses the bytes whose address has bit k clear.
- R4: The code packs the odd halves into bits [11:0] and the even halves into bits [23:12]. Within each half, bits 0..2 are column bits k=0..2 and bits 3..11 are row bits k=0..8.
- R5: In word mode (wide_mode=1), each accepted transfer supplies two bytes. din[7:0] takes the current address and din[15:8] takes the next one. In byte mode, only din[7:0] is used.
- R6: Exactly 512 bytes are absorbed. Bytes offered after that leave the code, done and the sector counter unchanged until a clear.
- R7: done is high for exactly one cycle: the cycle after the edge that absorbs byte 511. The code is final in that same cycle and holds afterwards.
- R8: A clear empties the accumulators. If valid is high in the same cycle, that byte (or word) becomes address 0 of the new sector.
- R9: The sector counter increases by one at each completion and wraps modulo 2^SECT_W. It is cleared only by reset.
- R10: If the data of two sectors differ in exactly one bit, at byte address A and bit index j, the XOR of their codes is {~{A,j}, {A,j}}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start a new sector; takes priority over accumulation |
| vld | input | 1 | Data on din is valid this cycle |
| wide_mode | input | 1 | 1: two bytes per transfer, low byte first; 0: one byte |
| din | input | 16 | Data bus; byte mode uses [7:0] |
| ecc | output | 24 | Code: odd halves [11:0], even halves [23:12] |
| done | output | 1 | One-cycle pulse when the sector is complete |
| sector | output | 3 | Count of completed sectors, modulo 8 |

## Verification
Several properties are checked on every cycle:
- done never lasts two cycles, and the sector counter moves by exactly one whenever done is high.
- The byte count never exceeds 512, and a full sector's code stays frozen until a clear.
- A clear with no data leaves empty accumulators.
- The upper byte lane is never used without the lower one.

Only the bench scenarios can show that the parity values themselves are right. These scenarios include:
- single-byte sectors whose codes can be worked out by hand, in both bus modes;
- random sectors compared against an independent position-XOR model;
- the single-bit-flip syndrome;
- a clear that arrives together with the first byte.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int ECC_BYTE_W = 8;
  localparam int ECC_ADDR_W = 9;
  localparam int ECC_SECT_W = 3;
  localparam int ECC_LANES  = 2;

  typedef enum logic {
    BUS_BYTE = 1'b0,
    BUS_WORD = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/ecc_lane_term.sv
module ecc_lane_term #(
  parameter int BYTE_W = ecc_pkg::ECC_BYTE_W,
  parameter int ADDR_W = ecc_pkg::ECC_ADDR_W,
  localparam int COL_W = $clog2(BYTE_W),
  localparam int HALF  = COL_W + ADDR_W
) (
  input  logic              en,
  input  logic [BYTE_W-1:0] data,
  input  logic [ADDR_W-1:0] addr,
  output logic [2*HALF-1:0] term
);
  logic [HALF-1:0] odd_h, even_h;
  logic            byte_par;

  always_comb begin
    odd_h    = '0;
    even_h   = '0;
    byte_par = ^data;
    // column halves: split bit positions by each index bit
    for (int j = 0; j < BYTE_W; j++) begin
      for (int k = 0; k < COL_W; k++) begin
        if (((j >> k) & 1) == 1) odd_h[k]  = odd_h[k]  ^ data[j];
        else                     even_h[k] = even_h[k] ^ data[j];
      end
    end
    // row halves: split byte addresses by each address bit
    for (int k = 0; k < ADDR_W; k++) begin
      if (addr[k]) odd_h[COL_W+k]  = odd_h[COL_W+k]  ^ byte_par;
      else         even_h[COL_W+k] = even_h[COL_W+k] ^ byte_par;
    end
    term = en ? {even_h, odd_h} : '0;
  end
endmodule

// File: rtl/ecc_stream_ctrl.sv
module ecc_stream_ctrl #(
  parameter int ADDR_W = ecc_pkg::ECC_ADDR_W,
  parameter int SECT_W = ecc_pkg::ECC_SECT_W,
  localparam int CNT_W = ADDR_W + 1,
  localparam int BYTES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              vld,
  input  logic              wide_mode,
  output logic [1:0]        lane_en,
  output logic [ADDR_W-1:0] base_addr,
  output logic              full,
  output logic              done,
  output logic [SECT_W-1:0] sector
);
  logic [CNT_W-1:0] cnt, base, nxt;
  logic             finish;

  always_comb begin
    base       = clr ? '0 : cnt;
    lane_en[0] = vld && (base < CNT_W'(BYTES));
    lane_en[1] = vld && (wide_mode == ecc_pkg::BUS_WORD) && ((base + CNT_W'(1)) < CNT_W'(BYTES));
    nxt        = base + CNT_W'(lane_en[0]) + CNT_W'(lane_en[1]);
    finish     = lane_en[0] && (nxt == CNT_W'(BYTES));
    base_addr  = base[ADDR_W-1:0];
    full       = (cnt == CNT_W'(BYTES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done   <= 1'b0;
      sector <= '0;
    end else begin
      cnt  <= nxt;
      done <= finish;
      if (finish) sector <= sector + SECT_W'(1);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BYTES)); // R6
  AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (rst)
    done |-> (sector - $past(sector)) == SECT_W'(1)); // R9
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int BYTE_W = ecc_pkg::ECC_BYTE_W,
  parameter int ADDR_W = ecc_pkg::ECC_ADDR_W,
  parameter int SECT_W = ecc_pkg::ECC_SECT_W,
  localparam int LANES  = ecc_pkg::ECC_LANES,
  localparam int COL_W  = $clog2(BYTE_W),
  localparam int HALF   = COL_W + ADDR_W,
  localparam int CODE_W = 2 * HALF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    vld,
  input  logic                    wide_mode,
  input  logic [LANES*BYTE_W-1:0] din,
  output logic [CODE_W-1:0]       ecc,
  output logic                    done,
  output logic [SECT_W-1:0]       sector
);
  logic [1:0]        lane_en;
  logic [ADDR_W-1:0] base_addr;
  logic              full;
  logic [CODE_W-1:0] acc, acc_n;
  logic [CODE_W-1:0] term [LANES];

  ecc_stream_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .vld(vld), .wide_mode(wide_mode),
    .lane_en(lane_en), .base_addr(base_addr), .full(full),
    .done(done), .sector(sector)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ecc_lane_term #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_term (
      .en(lane_en[i]),
      .data(din[i*BYTE_W +: BYTE_W]),
      .addr(base_addr + ADDR_W'(i)),
      .term(term[i])
    );
  end

  always_comb begin
    acc_n = clr ? '0 : acc;
    for (int i = 0; i < LANES; i++) acc_n = acc_n ^ term[i];
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc_n;
  end

  assign ecc = acc;

  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && !clr) |=> $stable(acc)); // R6
  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (rst)
    (clr && !vld) |=> (acc == '0)); // R8
  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
    lane_en[1] |-> lane_en[0]); // R5
endmodule

// File: tb/sim_nand_hamming_ecc.sv
module sim_nand_hamming_ecc;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;
  localparam int NVEC = 9;
  // {wide, position, data16, expected code}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b0, 9'd0,   16'h0001, 24'hFFF000},
    {1'b0, 9'd511, 16'h0080, 24'h000FFF},
    {1'b0, 9'd511, 16'h0001, 24'h007FF8},
    {1'b0, 9'd0,   16'h0080, 24'hFF8007},
    {1'b0, 9'd5,   16'h0003, 24'h001001},
    {1'b0, 9'd3,   16'h00FF, 24'h000000},
    {1'b1, 9'd0,   16'h0100, 24'hFF7008},
    {1'b1, 9'd0,   16'h0001, 24'hFFF000},
    {1'b1, 9'd255, 16'h8000, 24'h000FFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        vld = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] din = '0;
  logic [23:0] ecc;
  logic        done;
  logic [2:0]  sector;

  int errors = 0;
  int checks = 0;
  int exp_sect = 0;
  logic [7:0]  mem [512];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  nand_hamming_ecc u0 (
    .clk(clk), .rst(rst), .clr(clr), .vld(vld), .wide_mode(wide_mode),
    .din(din), .ecc(ecc), .done(done), .sector(sector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: odd half = XOR of positions {addr,bit} of set bits, even half = XOR of their complements
  function automatic logic [23:0] model();
    logic [11:0] o = '0;
    logic [11:0] e = '0;
    for (int a = 0; a < 512; a++)
      for (int j = 0; j < 8; j++)
        if (mem[a][j]) begin
          o = o ^ {9'(a), 3'(j)};
          e = e ^ ~{9'(a), 3'(j)};
        end
    return {e, o};
  endfunction

  task automatic fill_random();
    for (int a = 0; a < 512; a++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mem[a] = lfsr[7:0] ^ lfsr[23:16];
    end
  endtask

  task automatic fill_zero();
    for (int a = 0; a < 512; a++) mem[a] = 8'h00;
  endtask

  // Streams mem; on return the current negedge is the cycle done should be high.
  task automatic run_stream(input logic wide, input logic clr_with_first);
    int n;
    n = wide ? 256 : 512;
    if (!clr_with_first) begin
      @(negedge clk); clr = 1'b1; vld = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clr = clr_with_first && (i == 0);
      vld = 1'b1;
      wide_mode = wide;
      din = wide ? {mem[2*i+1], mem[2*i]} : {8'h5A, mem[i]};
    end
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
    exp_sect++;
    check(done === 1'b1, "R7 done after last byte", 32'(done), 32'd1);
    check(sector === 3'(exp_sect), "R9 sector count", 32'(sector), 32'(3'(exp_sect)));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WDOG_LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG_LIMIT);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] held, e1, e2, syn;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(ecc === 24'h0, "R1 code in reset", 32'(ecc), 32'h0);
    check(done === 1'b0, "R1 done in reset", 32'(done), 32'h0);
    check(sector === 3'd0, "R1 sector in reset", 32'(sector), 32'h0);
    rst = 1'b0;

    // R2 R3 R4 R5 hand-worked single-byte sectors
    for (int v = 0; v < NVEC; v++) begin
      fill_zero();
      if (VEC[v][49]) begin
        mem[2*VEC[v][48:40]]   = VEC[v][31:24];
        mem[2*VEC[v][48:40]+1] = VEC[v][39:32];
      end else begin
        mem[VEC[v][48:40]] = VEC[v][31:24];
      end
      run_stream(VEC[v][49], 1'b0);
      check(ecc === VEC[v][23:0], "R2 R3 R4 R5 vector code", 32'(ecc), 32'(VEC[v][23:0]));
    end

    // R7 done lasts one cycle, code holds
    held = ecc;
    @(negedge clk);
    check(done === 1'b0, "R7 done falls", 32'(done), 32'h0);
    check(ecc === held, "R7 code holds", 32'(ecc), 32'(held));

    // R2 R3 random byte-mode sector vs model
    fill_random();
    run_stream(1'b0, 1'b0);
    check(ecc === model(), "R3 random byte mode", 32'(ecc), 32'(model()));

    // R6 bytes beyond the sector are ignored
    held = ecc;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); vld = 1'b1; wide_mode = i[0]; din = 16'hA5C3;
      @(negedge clk); vld = 1'b0;
      check(ecc === held && done === 1'b0, "R6 extra byte ignored", 32'(ecc), 32'(held));
    end
    check(sector === 3'(exp_sect), "R6 sector unchanged", 32'(sector), 32'(3'(exp_sect)));

    // R5 random word-mode sector vs model
    fill_random();
    run_stream(1'b1, 1'b0);
    check(ecc === model(), "R5 random word mode", 32'(ecc), 32'(model()));

    // R8 clear in the same cycle as the first byte (accumulator holds old code)
    fill_random();
    run_stream(1'b0, 1'b1);
    check(ecc === model(), "R8 clear with first byte", 32'(ecc), 32'(model()));

    // R10 single-bit-flip syndrome
    fill_random();
    run_stream(1'b0, 1'b0);
    e1 = ecc;
    mem[300][6] = ~mem[300][6];
    run_stream(1'b0, 1'b0);
    e2 = ecc;
    syn = e1 ^ e2;
    check(syn === {~{9'd300, 3'd6}, {9'd300, 3'd6}}, "R10 flip syndrome", 32'(syn),
          32'({~{9'd300, 3'd6}, {9'd300, 3'd6}}));

    // R8 clear alone empties the code
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(ecc === 24'h0, "R8 clear empties", 32'(ecc), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule